// File: doc/BRIEF.md
# Accumulator Normalizer with Index Count

This block normalizes a signed word held either in the 24-bit accumulator alone or in the combined accumulator/auxiliary pair. The combined pair is treated as a 47-bit quantity: the whole accumulator sits above the low 23 bits of the auxiliary register, and the auxiliary sign bit is left out. A left normalize moves the value toward the top, one position per clock, until the two highest bits differ or a count limit is reached. The number of positions moved is then subtracted from an addressed index register. A right normalize is conditional. When the overflow flag is set, it undoes one position of overflow with an arithmetic right shift and adds one to the index register.

The caller presents the operation select, the index number, the overflow flag, both data registers and the whole index register file, then pulses `start`. When `done` pulses, the outputs hold the updated registers and the updated index file. Index numbers 6 and 7 turn any operation into a no-op.

Top module: `acc_normalizer`

## Requirements
- R1: After reset, `done` is 0 and `acc_out`, `aux_out` and `xr_out` are all zero.
- R2: `start` is taken only while the block is idle. A `start` pulse during an operation is ignored, and the result is the one for the first request.
- R3: A 24-bit left normalize (`wide`=0, `right`=0) repeats a one-position left shift of the accumulator, with a zero entering at bit 0. It stops when bit 23 differs from bit 22, or after 23 shifts. `aux_out` equals `aux_in`.
- R4: A combined left normalize (`wide`=1, `right`=0) does the same on the 47-bit value {accumulator, auxiliary bits 22..0}, with a limit of 46 shifts.
- R5: After a left normalize, index register `xsel` becomes its old value minus the shift count k, computed as the ones'-complement sum of the old value and the bitwise inverse of k. All other index registers are unchanged.
- R6: A right normalize with `ovf`=1 shifts the accumulator (24-bit form) or the 47-bit combined value (`wide`=1) right by one, keeping the sign. It adds 1 to index register `xsel` by ones'-complement addition.
- R7: A right normalize with `ovf`=0 leaves the accumulator, the auxiliary bits 22..0 and the index file unchanged.
- R8: In every combined-form operation with `xsel` below 6, including a right normalize with `ovf`=0, `aux_out[23]` ends equal to `acc_out[23]`.
- R9: With `xsel` equal to 6 or 7, every operation leaves `acc_out`, `aux_out` and `xr_out` equal to the captured inputs.
- R10: `done` is a one-cycle pulse. For a left normalize it comes k+1 clock edges after the edge that takes `start`. For a right normalize or a no-op it comes 1 edge after.
- R11: Ones'-complement addition of 16-bit values a and b forms the 17-bit sum a+b, then adds its bit 16 back into its low 16 bits (end-around carry).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| wide | input | 1 | 1: combined 47-bit form, 0: accumulator only |
| right | input | 1 | 1: right normalize, 0: left normalize |
| xsel | input | 3 | Index register number |
| ovf | input | 1 | Overflow flag, gates the right normalize |
| acc_in | input | 24 | Accumulator value |
| aux_in | input | 24 | Auxiliary register value |
| xr_in | input | 128 | Index register file, register i at bits 16i+15..16i |
| acc_out | output | 24 | Resulting accumulator |
| aux_out | output | 24 | Resulting auxiliary register |
| xr_out | output | 128 | Resulting index register file, same layout as `xr_in` |
| done | output | 1 | One-cycle pulse when the results are final |

## Verification
The left normalize is swept with a single leading one at every position, and with its inverse (a single leading zero in a negative word), in both widths. This separates the stop condition from the count limit and checks the shift count, the final value and the latency position by position. The zero word and the all-ones word reach the limit. Right normalizes cross `ovf` with both widths, both signs and index values 0, 7FFF and FFFF, which exercise the end-around carry. A sweep of every index number over every operation separates the no-op numbers from the others. A second `start` during a long operation shows that requests are not taken while busy.

// File: rtl/acc_normalizer.sv
module acc_normalizer #(
  parameter int W  = 24,
  parameter int XW = 16,
  parameter int NX = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                wide,
  input  logic                right,
  input  logic [$clog2(NX)-1:0] xsel,
  input  logic                ovf,
  input  logic [W-1:0]        acc_in,
  input  logic [W-1:0]        aux_in,
  input  logic [NX*XW-1:0]    xr_in,
  output logic [W-1:0]        acc_out,
  output logic [W-1:0]        aux_out,
  output logic [NX*XW-1:0]    xr_out,
  output logic                done
);
  localparam int SW = $clog2(NX);
  localparam int CL = 2*W - 1;
  localparam int CW = $clog2(CL) + 1;
  localparam logic [CW-1:0] LIM_N = CW'(W-1);
  localparam logic [CW-1:0] LIM_W = CW'(2*W-2);

  function automatic logic [XW-1:0] oc_add(input logic [XW-1:0] a, input logic [XW-1:0] b);
    logic [XW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[XW-1:0] + {{(XW-1){1'b0}}, s[XW]};
  endfunction

  logic          busy_q, wide_q, right_q, ovf_q, noop_q, done_q;
  logic [SW-1:0] sel_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  acc_q, aux_q;
  logic [XW-1:0] xr_q [NX];

  wire [CL-1:0]  comb    = {acc_q, aux_q[W-2:0]};
  wire [CL-1:0]  comb_l  = {comb[CL-2:0], 1'b0};
  wire [CL-1:0]  comb_r  = {comb[CL-1], comb[CL-1:1]};
  wire [CW-1:0]  lim     = wide_q ? LIM_W : LIM_N;
  wire           stop_l  = (acc_q[W-1] ^ acc_q[W-2]) || (cnt_q == lim);
  wire [XW-1:0]  xr_cur  = xr_q[sel_q];
  wire [XW-1:0]  xr_dec  = oc_add(xr_cur, ~XW'(cnt_q));
  wire [XW-1:0]  xr_inc  = oc_add(xr_cur, {{(XW-1){1'b0}}, 1'b1});
  wire           is_noop = (xsel >= SW'(NX-2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; wide_q <= 1'b0; right_q <= 1'b0; ovf_q <= 1'b0;
      noop_q <= 1'b0; done_q <= 1'b0; sel_q <= '0; cnt_q <= '0;
      acc_q <= '0; aux_q <= '0;
      for (int i = 0; i < NX; i++) xr_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          wide_q  <= wide;
          right_q <= right;
          ovf_q   <= ovf;
          noop_q  <= is_noop;
          sel_q   <= xsel;
          cnt_q   <= '0;
          acc_q   <= acc_in;
          aux_q   <= aux_in;
          for (int i = 0; i < NX; i++) xr_q[i] <= xr_in[i*XW +: XW];
        end
      end else if (noop_q) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (right_q) begin
        if (ovf_q) begin
          xr_q[sel_q] <= xr_inc;
          if (wide_q) begin
            acc_q <= comb_r[CL-1:W-1];
            aux_q[W-2:0] <= comb_r[W-2:0];
          end else begin
            acc_q <= {acc_q[W-1], acc_q[W-1:1]};
          end
        end
        if (wide_q) aux_q[W-1] <= acc_q[W-1];
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (stop_l) begin
        xr_q[sel_q] <= xr_dec;
        if (wide_q) aux_q[W-1] <= acc_q[W-1];
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (wide_q) begin
          acc_q <= comb_l[CL-1:W-1];
          aux_q[W-2:0] <= comb_l[W-2:0];
        end else begin
          acc_q <= {acc_q[W-2:0], 1'b0};
        end
      end
    end
  end

  assign acc_out = acc_q;
  assign aux_out = aux_q;
  assign done    = done_q;

  generate
    for (genvar g = 0; g < NX; g++) begin : g_xr
      assign xr_out[g*XW +: XW] = xr_q[g];
    end
  endgenerate
endmodule

// File: rtl/acc_normalizer_chk.sv
module acc_normalizer_chk #(
  parameter int W  = 24,
  parameter int XW = 16,
  parameter int NX = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    done,
  input logic [W-1:0]            acc_out,
  input logic [W-1:0]            aux_out,
  input logic [NX*XW-1:0]        xr_out,
  input logic                    busy_q,
  input logic                    wide_q,
  input logic                    right_q,
  input logic                    ovf_q,
  input logic                    noop_q,
  input logic [$clog2(NX)-1:0]   sel_q,
  input logic [$clog2(2*W-1):0]  cnt_q
);
  localparam int CW = $clog2(2*W-1) + 1;
  wire [CW-1:0] lim = wide_q ? CW'(2*W-2) : CW'(W-1);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> $stable(sel_q));

  assert_left_normalized_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !right_q && !noop_q && cnt_q != lim) |-> (acc_out[W-1] != acc_out[W-2]));

  assert_sign_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wide_q && !noop_q) |-> (aux_out[W-1] == acc_out[W-1]));

  assert_noop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && noop_q) |-> ($stable(acc_out) && $stable(aux_out) && $stable(xr_out)));

  assert_no_ovf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && right_q && !ovf_q && !noop_q) |-> ($stable(acc_out) && $stable(xr_out)));
endmodule

bind acc_normalizer acc_normalizer_chk #(.W(W), .XW(XW), .NX(NX)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .acc_out(acc_out), .aux_out(aux_out), .xr_out(xr_out),
  .busy_q(busy_q), .wide_q(wide_q), .right_q(right_q), .ovf_q(ovf_q),
  .noop_q(noop_q), .sel_q(sel_q), .cnt_q(cnt_q)
);

// File: tb/acc_normalizer_bench.sv
`timescale 1ns/1ps
module acc_normalizer_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wide = 1'b0, right = 1'b0, ovf = 1'b0;
  logic [2:0] xsel = '0;
  logic [23:0] acc_in = '0, aux_in = '0;
  logic [127:0] xr_in = '0;
  logic [23:0] acc_out, aux_out;
  logic [127:0] xr_out;
  logic done;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  acc_normalizer u_acc_normalizer (
    .clk(clk), .rst_n(rst_n), .start(start), .wide(wide), .right(right),
    .xsel(xsel), .ovf(ovf), .acc_in(acc_in), .aux_in(aux_in), .xr_in(xr_in),
    .acc_out(acc_out), .aux_out(aux_out), .xr_out(xr_out), .done(done));

  function automatic logic [15:0] ocadd(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s = {1'b0, a} + {1'b0, b};
    return s[15:0] + 16'(s[16]);
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input bit w, input bit r, input int sel, input bit of,
                     input logic [23:0] a, input logic [23:0] b, input logic [15:0] xv);
    logic [127:0] file, exf;
    logic [46:0] c;
    logic [23:0] ea, eb;
    int k, lim, lat, elat;
    for (int i = 0; i < 8; i++) file[i*16 +: 16] = 16'h1357 + 16'(i * 16'h0911);
    if (sel < 8) file[sel*16 +: 16] = xv;
    exf = file; ea = a; eb = b; elat = 1;
    if (sel < 6) begin
      if (r) begin
        if (of) begin
          if (w) begin
            c = {a, b[22:0]}; c = {c[46], c[46:1]};
            ea = c[46:23]; eb = {b[23], c[22:0]};
          end else ea = {a[23], a[23:1]};
          exf[sel*16 +: 16] = ocadd(xv, 16'd1);
        end
      end else begin
        c = w ? {a, b[22:0]} : {a, 23'd0};
        lim = w ? 46 : 23; k = 0;
        while (k < lim && c[46] == c[45]) begin c = c << 1; k++; end
        ea = c[46:23];
        if (w) eb = {b[23], c[22:0]};
        exf[sel*16 +: 16] = ocadd(xv, ~16'(k));
        elat = k + 1;
      end
      if (w) eb[23] = ea[23];
    end
    @(negedge clk);
    wide = w; right = r; xsel = 3'(sel); ovf = of; acc_in = a; aux_in = b; xr_in = file; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 0;
    do begin @(negedge clk); lat++; end while (!done && lat < 100);
    check({req, " acc"}, 128'(acc_out), 128'(ea));
    check({req, " aux"}, 128'(aux_out), 128'(eb));
    check((sel >= 6) ? "R9 xr" : (r ? "R6/R11 xr" : "R5/R11 xr"), xr_out, exf);
    check("R10 latency", 128'(lat), 128'(elat));
    if (w && sel < 6) check("R8 sign copy", 128'(aux_out[23]), 128'(acc_out[23]));
    @(negedge clk);
    check("R10 pulse", 128'(done), 128'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done", 128'(done), 128'd0);
    check("R1 regs", {acc_out, aux_out, 80'd0}, 128'd0);
    check("R1 xr", xr_out, 128'd0);
    rst_n = 1'b1;

    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 2; w++)
        for (int r = 0; r < 2; r++)
          run(s >= 6 ? "R9" : (r ? "R6" : (w ? "R4" : "R3")), w[0], r[0], s, 1'b1,
              24'h0000F0, 24'h923456, 16'h0005);

    for (int p = 0; p < 24; p++) begin
      run("R3 pos", 1'b0, 1'b0, p % 6, 1'b0, 24'd1 << p, 24'hA5A5A5, 16'(p * 16'h0EF1));
      run("R3 neg", 1'b0, 1'b0, (p + 3) % 6, 1'b0, ~(24'd1 << p), 24'h5A5A5A, 16'hFFFF - 16'(p));
    end
    run("R3 zero", 1'b0, 1'b0, 2, 1'b0, 24'h000000, 24'h111111, 16'h0000);
    run("R3 ones", 1'b0, 1'b0, 3, 1'b0, 24'hFFFFFF, 24'h222222, 16'hFFFF);

    for (int p = 0; p < 47; p++) begin
      logic [46:0] v = 47'd1 << p;
      run("R4 pos", 1'b1, 1'b0, p % 6, 1'b0, v[46:23], {1'b1, v[22:0]}, 16'(p * 16'h0321));
      v = ~v;
      run("R4 neg", 1'b1, 1'b0, (p + 1) % 6, 1'b0, v[46:23], {1'b0, v[22:0]}, 16'h8000 + 16'(p));
    end
    run("R4 zero", 1'b1, 1'b0, 0, 1'b0, 24'h000000, 24'h800000, 16'h0040);

    for (int w = 0; w < 2; w++)
      for (int o = 0; o < 2; o++)
        for (int v = 0; v < 3; v++) begin
          logic [23:0] a = (v == 0) ? 24'h800001 : ((v == 1) ? 24'h7FFFFE : 24'h000001);
          logic [15:0] x = (v == 0) ? 16'hFFFF : ((v == 1) ? 16'h7FFF : 16'h0000);
          run(o ? "R6" : "R7", w[0], 1'b1, v + 1, o[0], a, (v == 1) ? 24'hFABCDE : 24'h7ABCDE, x);
        end

    @(negedge clk);
    wide = 1'b0; right = 1'b0; xsel = 3'd1; ovf = 1'b0; acc_in = 24'h000001;
    aux_in = 24'h0; xr_in = 128'd0; xr_in[31:16] = 16'd30; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    acc_in = 24'h400000; xsel = 3'd2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    check("R2 acc", 128'(acc_out), 128'(24'h400000));
    check("R2 xr", 128'(xr_out[47:16]), 128'({16'd0, 16'd8}));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule